// File: doc/BRIEF.md
# Link Error Event Detector

This block watches the received symbol stream of a ring physical layer one symbol pair (one byte) per clock. Alongside each pair it is given the current and previous line state (Active, Idle or Unknown), a signal-detect level and a marker saying that the byte was inserted by the elasticity buffer. From these inputs it decides whether the byte is a link error event. An event is reported as a one-cycle pulse and is counted in a saturating counter that can be read.

A sticky error flag, built as a two-state machine, remembers that an Active frame was cut off by a Halt. When the line later drops into an Unknown state straight from Active, the flag makes the block count pairs that are neither a clean halt, an idle nor a start delimiter. The flag is cleared again by a start delimiter, or by the first such error seen in the Unknown state.

Each symbol is five bits: {control, code}. A control symbol has bit 4 set, and its code is Violation=0, Halt=1, Idle=2, J=3, K=4, Reset=5, Set=6, End=7, Quiet=8. A data symbol has bit 4 clear. An N symbol is a data symbol with code 0 (the data half of a mixed data/control byte). The first symbol of a pair is `sym_hi`. The line-state code is 00 Active, 01 Idle, and 10 or 11 Unknown.

The flag machine has two states. FLG_CLEAR goes to FLG_ARMED on transition ARM, which is an Active-state pair from the set rule R6. FLG_ARMED goes to FLG_CLEAR on transition DISARM_JK (rule R7) or DISARM_ULS (rule R5). Every other input leaves the state where it is.

Top module: `link_err_detector`

## Requirements
- R1: After reset `err_pulse` is 0, `link_flag` is 0 and `err_count` is 0.
- R2: In the Active state, with signal detect high and no stuff byte, a pair that holds a Violation in either position, or is Idle-Idle or Halt-Halt, is an event. Any other pair, such as data, JK or End-Reset, is not an event.
- R3: In the Active or Idle state, signal detect low on a non-stuff byte is an event.
- R4: In the Idle state, a non-stuff pair other than Idle-Idle or J-K is an event.
- R5: In an Unknown state whose previous state was Active, with the flag set and no stuff byte, a pair other than HH, HI, II or JK is an event and clears the flag. In an Unknown state, no other case is an event.
- R6: In the Active state, a pair whose second symbol is Halt and whose first symbol is Halt, N, Reset, Set or End sets the flag.
- R7: A J-K pair in the Active or Idle state clears the flag.
- R8: A stuff byte is never an event in any line state.
- R9: `err_count` rises by one for each event and holds at 255 once it reaches 255.
- R10: `cnt_clr` zeroes `err_count` at the next edge, and takes precedence over an event in the same cycle.
- R11: `err_pulse` and `link_flag` reflect the pair presented at the previous clock edge, and the pulse lasts one cycle for each event byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_hi | input | 5 | First symbol of the pair {control, code} |
| sym_lo | input | 5 | Second symbol of the pair |
| ls_cur | input | 2 | Current line state code |
| ls_prev | input | 2 | Previous line state code |
| sig_det | input | 1 | Signal detect, high when light is present |
| stuff_byte | input | 1 | Byte was inserted by the elasticity buffer |
| cnt_clr | input | 1 | Synchronous clear of the event counter |
| err_pulse | output | 1 | One-cycle link error event |
| link_flag | output | 1 | Sticky link error flag |
| err_count | output | 8 | Saturating event count |

## Verification
The bench sweeps every current and previous line-state code, both signal-detect levels, both stuff markers and both flag states. Each of these is crossed with every ordered pair drawn from all nine control symbols, the N symbol and one non-zero data symbol. Before each vector the flag is placed in a known state with an End-Halt or J-K byte, so each vector shows whether the flag gates Unknown-state errors and whether the pair arms or disarms it. The stuff and signal-detect axes separate the R8 suppression from the R3 loss-of-light rule. A final run of violation bytes pushes the counter past 255, and clears that coincide with events show that the clear takes precedence.

// File: rtl/lee_pkg.sv
package lee_pkg;

    localparam int SYM_W = 5;
    localparam int LS_W  = 2;

    typedef logic [SYM_W-1:0] sym_t;

    // control symbol codes, bit 4 = control
    localparam sym_t SYM_V = 5'b1_0000;
    localparam sym_t SYM_H = 5'b1_0001;
    localparam sym_t SYM_I = 5'b1_0010;
    localparam sym_t SYM_J = 5'b1_0011;
    localparam sym_t SYM_K = 5'b1_0100;
    localparam sym_t SYM_R = 5'b1_0101;
    localparam sym_t SYM_S = 5'b1_0110;
    localparam sym_t SYM_T = 5'b1_0111;
    localparam sym_t SYM_N = 5'b0_0000;

    typedef enum logic [LS_W-1:0] {
        LS_ACTIVE = 2'b00,
        LS_IDLE   = 2'b01,
        LS_UNK_A  = 2'b10,
        LS_UNK_B  = 2'b11
    } line_state_e;

    typedef struct packed {
        logic has_viol;
        logic idle_idle;
        logic halt_halt;
        logic halt_idle;
        logic start_delim;
        logic halt_tail;
    } pair_info_t;

    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_ARMED = 1'b1
    } flag_state_e;

endpackage

// File: rtl/lee_pair_class.sv
module lee_pair_class
    import lee_pkg::*;
(
    input  sym_t       sym_hi,
    input  sym_t       sym_lo,
    output pair_info_t info
);
    logic hi_is_h;
    logic lo_is_h;
    logic hi_tail_ok;

    assign hi_is_h = (sym_hi == SYM_H);
    assign lo_is_h = (sym_lo == SYM_H);

    // first symbol that may precede a closing halt
    always_comb begin
        unique case (sym_hi)
            SYM_H, SYM_N, SYM_R, SYM_S, SYM_T: hi_tail_ok = 1'b1;
            default:                           hi_tail_ok = 1'b0;
        endcase
    end

    always_comb begin
        info.has_viol    = (sym_hi == SYM_V) || (sym_lo == SYM_V);
        info.idle_idle   = (sym_hi == SYM_I) && (sym_lo == SYM_I);
        info.halt_halt   = hi_is_h && lo_is_h;
        info.halt_idle   = hi_is_h && (sym_lo == SYM_I);
        info.start_delim = (sym_hi == SYM_J) && (sym_lo == SYM_K);
        info.halt_tail   = hi_tail_ok && lo_is_h;
    end
endmodule

// File: rtl/lee_qualifier.sv
module lee_qualifier
    import lee_pkg::*;
(
    input  line_state_e ls_cur,
    input  line_state_e ls_prev,
    input  logic        sig_det,
    input  logic        stuff_byte,
    input  pair_info_t  info,
    input  logic        flag_armed,
    output logic        event_hit,
    output logic        uls_hit
);
    logic uls_pair_bad;
    logic raw_hit;

    assign uls_pair_bad = !(info.halt_halt || info.halt_idle ||
                            info.idle_idle || info.start_delim);

    always_comb begin
        raw_hit = 1'b0;
        uls_hit = 1'b0;
        unique case (ls_cur)
            LS_ACTIVE: raw_hit = info.has_viol || info.idle_idle ||
                                 info.halt_halt || !sig_det;
            LS_IDLE:   raw_hit = !(info.idle_idle || info.start_delim) ||
                                 !sig_det;
            LS_UNK_A, LS_UNK_B: begin
                uls_hit = (ls_prev == LS_ACTIVE) && flag_armed &&
                          !stuff_byte && uls_pair_bad;
                raw_hit = uls_hit;
            end
            default: raw_hit = 1'b0;
        endcase
    end

    assign event_hit = raw_hit && !stuff_byte;
endmodule

// File: rtl/lee_flag_fsm.sv
module lee_flag_fsm
    import lee_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  line_state_e ls_cur,
    input  pair_info_t  info,
    input  logic        uls_hit,
    output logic        armed
);
    flag_state_e state_q;
    flag_state_e state_d;
    logic        in_known;

    assign in_known = (ls_cur == LS_ACTIVE) || (ls_cur == LS_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: begin
                // ARM
                if (ls_cur == LS_ACTIVE && info.halt_tail) state_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                // DISARM_JK, DISARM_ULS
                if (in_known && info.start_delim) state_d = FLG_CLEAR;
                else if (uls_hit)                 state_d = FLG_CLEAR;
            end
            default: state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        armed = (state_q == FLG_ARMED);
    end
endmodule

// File: rtl/lee_sat_cnt.sv
module lee_sat_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     count <= '0;
        else if (clr)                   count <= '0;
        else if (inc && count != CNT_MAX) count <= count + 1'b1;
    end
endmodule

// File: rtl/link_err_detector.sv
module link_err_detector
    import lee_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       sym_hi,
    input  logic [4:0]       sym_lo,
    input  logic [1:0]       ls_cur,
    input  logic [1:0]       ls_prev,
    input  logic             sig_det,
    input  logic             stuff_byte,
    input  logic             cnt_clr,
    output logic             err_pulse,
    output logic             link_flag,
    output logic [CNT_W-1:0] err_count
);
    pair_info_t  info;
    line_state_e cur_e;
    line_state_e prev_e;
    logic        event_hit;
    logic        uls_hit;

    assign cur_e  = line_state_e'(ls_cur);
    assign prev_e = line_state_e'(ls_prev);

    lee_pair_class u_class (
        .sym_hi (sym_hi),
        .sym_lo (sym_lo),
        .info   (info)
    );

    lee_qualifier u_qual (
        .ls_cur     (cur_e),
        .ls_prev    (prev_e),
        .sig_det    (sig_det),
        .stuff_byte (stuff_byte),
        .info       (info),
        .flag_armed (link_flag),
        .event_hit  (event_hit),
        .uls_hit    (uls_hit)
    );

    lee_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ls_cur  (cur_e),
        .info    (info),
        .uls_hit (uls_hit),
        .armed   (link_flag)
    );

    lee_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (event_hit),
        .count (err_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_pulse <= 1'b0;
        else        err_pulse <= event_hit;
    end
endmodule

// File: rtl/lee_chk.sv
module lee_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       sym_hi,
    input logic [4:0]       sym_lo,
    input logic [1:0]       ls_cur,
    input logic             stuff_byte,
    input logic             cnt_clr,
    input logic             err_pulse,
    input logic             link_flag,
    input logic [CNT_W-1:0] err_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R8
    stuff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_byte |=> !err_pulse);

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (err_count == '0));

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && err_count == CNT_MAX) |=> (err_count == CNT_MAX));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && err_pulse && !$past(cnt_clr) && $past(err_count) != CNT_MAX)
        |-> (err_count == $past(err_count) + 1'b1));

    // R7
    jk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_cur[1] == 1'b0 && sym_hi == 5'b1_0011 && sym_lo == 5'b1_0100)
        |=> !link_flag);

    // R6
    halt_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_cur == 2'b00 && sym_hi == 5'b1_0111 && sym_lo == 5'b1_0001)
        |=> link_flag);
endmodule

bind link_err_detector lee_chk #(.CNT_W(CNT_W)) u_lee_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_hi     (sym_hi),
    .sym_lo     (sym_lo),
    .ls_cur     (ls_cur),
    .stuff_byte (stuff_byte),
    .cnt_clr    (cnt_clr),
    .err_pulse  (err_pulse),
    .link_flag  (link_flag),
    .err_count  (err_count)
);

// File: tb/link_err_detector_bench.sv
module link_err_detector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] sym_hi = '0;
    logic [4:0] sym_lo = '0;
    logic [1:0] ls_cur = '0;
    logic [1:0] ls_prev = '0;
    logic       sig_det = 1'b1;
    logic       stuff_byte = 1'b0;
    logic       cnt_clr = 1'b0;
    logic       err_pulse;
    logic       link_flag;
    logic [7:0] err_count;

    int checks = 0;
    int fails = 0;
    bit m_flag = 1'b0;
    int m_cnt = 0;
    int vec = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_err_detector u_link_err_detector (
        .clk(clk), .rst_n(rst_n), .sym_hi(sym_hi), .sym_lo(sym_lo),
        .ls_cur(ls_cur), .ls_prev(ls_prev), .sig_det(sig_det),
        .stuff_byte(stuff_byte), .cnt_clr(cnt_clr),
        .err_pulse(err_pulse), .link_flag(link_flag), .err_count(err_count)
    );

    // symbol index 0..8 = control codes, 9 = N, 10 = data 7
    function automatic logic [4:0] pick(int i);
        if (i < 9)  return {1'b1, 4'(i)};
        if (i == 9) return 5'b0_0000;
        return 5'b0_0111;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (vector %0d)", req, act, exp, vec);
        end
    endtask

    task automatic apply(int cur, int prev, bit sd, bit st, logic [4:0] a,
                         logic [4:0] b, bit clr);
        bit ev, nf, known, uls, vio, ii, hh, hi, jk, tail;
        string tag;
        sym_hi = a; sym_lo = b; ls_cur = 2'(cur); ls_prev = 2'(prev);
        sig_det = sd; stuff_byte = st; cnt_clr = clr;
        vio  = (a == 5'h10) || (b == 5'h10);
        ii   = (a == 5'h12) && (b == 5'h12);
        hh   = (a == 5'h11) && (b == 5'h11);
        hi   = (a == 5'h11) && (b == 5'h12);
        jk   = (a == 5'h13) && (b == 5'h14);
        tail = (b == 5'h11) && (a == 5'h11 || a == 5'h00 || a == 5'h15 ||
                                a == 5'h16 || a == 5'h17);
        known = (cur < 2);
        uls = !known && prev == 0 && m_flag && !st && !(hh || hi || ii || jk);
        if (cur == 0)      ev = vio || ii || hh || !sd;
        else if (cur == 1) ev = !(ii || jk) || !sd;
        else               ev = uls;
        ev = ev && !st;
        nf = m_flag;
        if (cur == 0 && tail)   nf = 1'b1;
        else if (known && jk)   nf = 1'b0;
        else if (uls)           nf = 1'b0;
        if (st)            tag = "R8";
        else if (cur >= 2) tag = "R5";
        else if (!sd)      tag = "R3";
        else if (cur == 0) tag = "R2";
        else               tag = "R4";
        @(negedge clk);
        check({tag, " R11 pulse"}, int'(err_pulse), int'(ev));
        check((cur == 0 && tail) ? "R6 flag" : (known && jk) ? "R7 flag" : "R5 flag",
              int'(link_flag), int'(nf));
        if (clr) m_cnt = 0;
        else if (ev && m_cnt < 255) m_cnt++;
        check(clr ? "R10 count" : "R9 count", int'(err_count), m_cnt);
        m_flag = nf;
        vec++;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pulse", int'(err_pulse), 0);
        check("R1 flag", int'(link_flag), 0);
        check("R1 count", int'(err_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", int'(err_count), 0);

        for (int cur = 0; cur < 4; cur++)
            for (int prev = 0; prev < 4; prev++)
                for (int sd = 0; sd < 2; sd++)
                    for (int st = 0; st < 2; st++)
                        for (int fl = 0; fl < 2; fl++)
                            for (int a = 0; a < 11; a++)
                                for (int b = 0; b < 11; b++) begin
                                    // place flag with End-Halt (arm) or J-K (disarm)
                                    apply(0, 0, 1'b1, 1'b0, fl ? 5'h17 : 5'h13,
                                          fl ? 5'h11 : 5'h14, 1'b0);
                                    apply(cur, prev, sd[0], st[0], pick(a), pick(b),
                                          (vec % 97) == 0);
                                end

        // R9 saturation run, then R10 clear against an event
        apply(0, 0, 1'b1, 1'b0, 5'h13, 5'h14, 1'b1);
        for (int i = 0; i < 300; i++) apply(0, 0, 1'b1, 1'b0, 5'h10, 5'h10, 1'b0);
        check("R9 saturated", int'(err_count), 255);
        apply(0, 0, 1'b1, 1'b0, 5'h10, 5'h10, 1'b1);
        check("R10 clear wins", int'(err_count), 0);
        apply(0, 0, 1'b1, 1'b0, 5'h10, 5'h02, 1'b0);
        check("R9 after clear", int'(err_count), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule